// File: doc/BRIEF.md
# PLL Divider Coefficient Search Engine

This block finds the input divider, feedback multiplier and post-divider setting of a clock synthesizer that bring its output closest to a requested frequency. Software or a sequencer gives it two integer megahertz values, the desired output and the reference, and pulses a start line. The engine then walks a bounded search space one candidate at a time. It sends every quotient it needs through one shared restoring divider that produces one bit per cycle.

When the walk ends, the engine raises a one-cycle completion pulse. It then holds the chosen input divider, feedback multiplier, post-divider index, the error of that choice and an exact-match flag until the next request. The search is exhaustive within its pruned window, except that it stops at once when a candidate with zero error turns up. All arithmetic is plain unsigned integer math.

Top module: `pll_coeff_search`

## Requirements
- R1: After reset the engine is idle (busy 0, done 0) and reports the fallback result: input divider 255, multiplier 8, post-divider index 1, error 16'hFFFF, exact flag 0.
- R2: A start pulse is taken only while busy is 0. Busy rises on the next cycle and stays high up to and including the done cycle. A start seen while busy is high has no effect, and this includes a start in the done cycle itself.
- R3: Done is high for exactly one cycle per accepted start, and busy is 0 on the cycle after it.
- R4: Post-divider index i (0..14) selects the divide ratio 1,2,3,4,5,6,8,10,12,16,12,16,20,24,32 respectively. The reported index is always in 0..14.
- R5: The internal target T is twice the requested frequency, and the nominal VCO aim is V = T + floor(T/50). The VCO ceiling is max(2064, V). The index window runs from the first index among 0..13 whose ratio is at least clamp(floor(1000/V), 1, 32) up to the first index among 0..13 whose ratio is at least clamp(ceil(ceiling/V), 1, 32). A bound that no index in 0..13 reaches maps to 14. The requested frequency must be at least 1.
- R6: Input dividers M = 1, 2, ... are tried in turn. The comparison frequency is floor(ref/M). A value below 12 ends the M sweep for the current index, and a value above 38 skips that M.
- R7: For each M, the multipliers tried run from floor(T*ratio*M/ref) to the ceiling of the same quotient. A floor above 255 ends the M sweep, a candidate below 8 is skipped, and a candidate above 255 ends that M.
- R8: A candidate qualifies only if floor(ref*N/M) lies between 1000 and the VCO ceiling inclusive. Its error is |floor((vco + floor(ratio/2))/ratio) - T|.
- R9: A qualifying candidate replaces the held best only if its error is strictly smaller, so the earliest one in search order wins ties. The search ends as soon as an error of 0 is found. The reported error never rises during a search.
- R10: If no candidate qualifies, the fallback result of R1 is reported.
- R11: While idle and not started, all result outputs hold their values.
- R12: The exact flag is 1 exactly when the reported error is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a search (taken when idle) |
| target_i | input | TGT_W | Requested output frequency, MHz |
| ref_i | input | REF_W | Reference frequency, MHz |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle completion pulse |
| m_o | output | MW | Chosen input divider |
| n_o | output | MW | Chosen feedback multiplier |
| pl_o | output | 4 | Chosen post-divider index |
| err_o | output | ERR_W | Error of the chosen setting (all ones if none) |
| exact_o | output | 1 | Chosen setting has zero error |

## Verification
The completion pulse and the acceptance of a new request can meet in one cycle. This happens when a caller reacts to done by pulsing start at once. The bench drives start exactly in the done cycle and expects the engine to drop to idle and stay there, with no second done and no change of result. A start held one cycle longer must then be taken normally. The early exit on a zero error can also land on the last candidate of an index window, so the bench sweeps targets and references against its own model of the search, where both ways of ending occur.

// File: rtl/pll_coeff_search.sv
module pll_coeff_search #(
  parameter int TGT_W   = 10,
  parameter int REF_W   = 8,
  parameter int MW      = 8,
  parameter int ERR_W   = 16,
  parameter int VCO_MIN = 1000,
  parameter int VCO_MAX = 2064,
  parameter int U_MIN   = 12,
  parameter int U_MAX   = 38,
  parameter int M_MIN   = 1,
  parameter int M_MAX   = 255,
  parameter int N_MIN   = 8,
  parameter int N_MAX   = 255,
  parameter int PL_MIN  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [TGT_W-1:0] target_i,
  input  logic [REF_W-1:0] ref_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [MW-1:0]    m_o,
  output logic [MW-1:0]    n_o,
  output logic [3:0]       pl_o,
  output logic [ERR_W-1:0] err_o,
  output logic             exact_o
);

  localparam int DW = TGT_W + 1 + 6 + MW;
  localparam int CW = $clog2(DW + 1);
  localparam logic [MW:0] M_LO = (MW+1)'(M_MIN);
  localparam logic [MW:0] M_HI = (MW+1)'(M_MAX);
  localparam logic [MW:0] N_LO = (MW+1)'(N_MIN);
  localparam logic [MW:0] N_HI = (MW+1)'(N_MAX);
  localparam logic [3:0]  LAST_IDX = 4'd14;

  typedef enum logic [3:0] {
    S_IDLE, S_VT, S_HI, S_LO, S_PL, S_M, S_U, S_N, S_NC, S_VCO, S_LW, S_DONE
  } st_t;

  function automatic logic [5:0] ratio_of(input logic [3:0] i);
    case (i)
      4'd0: ratio_of = 6'd1;   4'd1: ratio_of = 6'd2;   4'd2: ratio_of = 6'd3;
      4'd3: ratio_of = 6'd4;   4'd4: ratio_of = 6'd5;   4'd5: ratio_of = 6'd6;
      4'd6: ratio_of = 6'd8;   4'd7: ratio_of = 6'd10;  4'd8: ratio_of = 6'd12;
      4'd9: ratio_of = 6'd16;  4'd10: ratio_of = 6'd12; 4'd11: ratio_of = 6'd16;
      4'd12: ratio_of = 6'd20; 4'd13: ratio_of = 6'd24; default: ratio_of = 6'd32;
    endcase
  endfunction

  function automatic logic [3:0] idx_of(input logic [5:0] b);
    logic [3:0] r;
    r = LAST_IDX;
    for (int i = 13; i >= 0; i--)
      if (ratio_of(4'(i)) >= b) r = 4'(i);
    return r;
  endfunction

  function automatic logic [5:0] clamp_ratio(input logic [DW-1:0] q);
    if (q == '0) return 6'd1;
    if (q > DW'(32)) return 6'd32;
    return q[5:0];
  endfunction

  st_t st;
  logic [DW-1:0]    tgt, vmax, vt, vt2;
  logic [REF_W-1:0] ref_r;
  logic [5:0]       hi_b;
  logic [3:0]       pl, pl_hi;
  logic [MW:0]      m, n, n2;
  logic [DW-1:0]    dq, dr, dd;
  logic [CW-1:0]    dc;
  logic [MW-1:0]    bm, bn;
  logic [3:0]       bpl;
  logic [ERR_W-1:0] be;

  logic [DW:0]   r_sh;
  logic          ge;
  logic [DW-1:0] r_sub, vt_n, vmax_n, dlt;
  logic [5:0]    rat;

  assign r_sh   = {dr, dq[DW-1]};
  assign ge     = r_sh >= {1'b0, dd};
  assign r_sub  = DW'(r_sh - {1'b0, dd});
  assign vt_n   = tgt + dq;
  assign vmax_n = (vt_n > DW'(VCO_MAX)) ? vt_n : DW'(VCO_MAX);
  assign rat    = ratio_of(pl);
  assign dlt    = (dq >= tgt) ? dq - tgt : tgt - dq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      tgt <= '0; vt <= '0; vmax <= '0; vt2 <= '0; ref_r <= '0;
      hi_b <= '0; pl <= '0; pl_hi <= '0; m <= '0; n <= '0; n2 <= '0;
      dq <= '0; dr <= '0; dd <= '0; dc <= '0;
      bm <= MW'(M_MAX); bn <= MW'(N_MIN); bpl <= 4'(PL_MIN); be <= '1;
    end else begin
      if (dc != '0) begin
        dq <= {dq[DW-2:0], ge};
        dr <= ge ? r_sub : r_sh[DW-1:0];
        dc <= dc - 1'b1;
      end
      case (st)
        S_IDLE: if (start_i) begin
          tgt   <= DW'({target_i, 1'b0});
          ref_r <= ref_i;
          bm <= MW'(M_MAX); bn <= MW'(N_MIN); bpl <= 4'(PL_MIN); be <= '1;
          dq <= DW'({target_i, 1'b0}); dd <= DW'(50); dr <= '0; dc <= CW'(DW);
          st <= S_VT;
        end
        S_VT: if (dc == '0) begin
          vt <= vt_n; vmax <= vmax_n;
          dq <= vmax_n + vt_n - 1'b1; dd <= vt_n; dr <= '0; dc <= CW'(DW);
          st <= S_HI;
        end
        S_HI: if (dc == '0) begin
          hi_b <= clamp_ratio(dq);
          dq <= DW'(VCO_MIN); dd <= vt; dr <= '0; dc <= CW'(DW);
          st <= S_LO;
        end
        S_LO: if (dc == '0) begin
          pl    <= idx_of(clamp_ratio(dq));
          pl_hi <= idx_of(hi_b);
          st    <= S_PL;
        end
        S_PL: begin
          if (pl > pl_hi) st <= S_DONE;
          else begin
            vt2 <= tgt * DW'(rat);
            m   <= M_LO;
            st  <= S_M;
          end
        end
        S_M: begin
          if (m > M_HI) begin
            pl <= pl + 1'b1; st <= S_PL;
          end else begin
            dq <= DW'(ref_r); dd <= DW'(m); dr <= '0; dc <= CW'(DW);
            st <= S_U;
          end
        end
        S_U: if (dc == '0) begin
          if (dq < DW'(U_MIN)) begin
            pl <= pl + 1'b1; st <= S_PL;
          end else if (dq > DW'(U_MAX)) begin
            m <= m + 1'b1; st <= S_M;
          end else begin
            dq <= DW'(vt2 * DW'(m)); dd <= DW'(ref_r); dr <= '0; dc <= CW'(DW);
            st <= S_N;
          end
        end
        S_N: if (dc == '0) begin
          if (dq > DW'(N_MAX)) begin
            pl <= pl + 1'b1; st <= S_PL;
          end else begin
            n  <= dq[MW:0];
            n2 <= dq[MW:0] + (MW+1)'(dr != '0);
            st <= S_NC;
          end
        end
        S_NC: begin
          if (n > n2 || n > N_HI) begin
            m <= m + 1'b1; st <= S_M;
          end else if (n < N_LO) begin
            n <= n + 1'b1;
          end else begin
            dq <= DW'(ref_r) * DW'(n); dd <= DW'(m); dr <= '0; dc <= CW'(DW);
            st <= S_VCO;
          end
        end
        S_VCO: if (dc == '0) begin
          if (dq >= DW'(VCO_MIN) && dq <= vmax) begin
            dq <= dq + DW'(rat >> 1); dd <= DW'(rat); dr <= '0; dc <= CW'(DW);
            st <= S_LW;
          end else begin
            n <= n + 1'b1; st <= S_NC;
          end
        end
        S_LW: if (dc == '0) begin
          if (dlt < DW'(be)) begin
            bm <= m[MW-1:0]; bn <= n[MW-1:0]; bpl <= pl; be <= dlt[ERR_W-1:0];
          end
          if (dlt == '0) st <= S_DONE;
          else begin
            n <= n + 1'b1; st <= S_NC;
          end
        end
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy_o  = st != S_IDLE;
  assign done_o  = st == S_DONE;
  assign m_o     = bm;
  assign n_o     = bn;
  assign pl_o    = bpl;
  assign err_o   = be;
  assign exact_o = be == '0;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o && !busy_o);                                   // R3
  AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> busy_o);                                               // R2
  AST_ERR_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> err_o <= $past(err_o));            // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable(m_o) && $stable(n_o) && $stable(pl_o) && $stable(err_o)); // R11
  AST_PL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> pl_o <= LAST_IDX);                                     // R4
  AST_N_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && err_o != '1) |-> (n_o >= MW'(N_MIN) && m_o >= MW'(M_MIN))); // R7
  AST_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && err_o == '1) |-> (m_o == MW'(M_MAX) && n_o == MW'(N_MIN) && pl_o == 4'(PL_MIN))); // R10
  AST_DIV_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> dc == '0);                                            // R2

endmodule

// File: tb/pll_coeff_search_test.sv
module pll_coeff_search_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [9:0] target_i = '0;
  logic [7:0] ref_i = '0;
  logic busy_o, done_o, exact_o;
  logic [7:0] m_o, n_o;
  logic [3:0] pl_o;
  logic [15:0] err_o;

  int applied = 0, bad = 0, cyc = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  pll_coeff_search uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .target_i(target_i), .ref_i(ref_i),
    .busy_o(busy_o), .done_o(done_o), .m_o(m_o), .n_o(n_o), .pl_o(pl_o),
    .err_o(err_o), .exact_o(exact_o)
  );

  function automatic int rt(int i);
    int t[15] = '{1, 2, 3, 4, 5, 6, 8, 10, 12, 16, 12, 16, 20, 24, 32};
    return t[i];
  endfunction

  function automatic int to_idx(int b);
    if (b < 1) b = 1;
    if (b > 32) b = 32;
    for (int i = 0; i < 14; i++) if (rt(i) >= b) return i;
    return 14;
  endfunction

  function automatic void model(input int f, input int r, output int om, output int on,
                                output int opl, output int oe);
    int tg, v, vmx, li, hi;
    bit stop;
    tg = 2 * f; v = tg + tg / 50; vmx = (v > 2064) ? v : 2064;
    hi = to_idx((vmx + v - 1) / v);
    li = to_idx(1000 / v);
    om = 255; on = 8; opl = 1; oe = 65535; stop = 0;
    for (int p = li; p <= hi && !stop; p++) begin
      int v2;
      v2 = tg * rt(p);
      for (int m = 1; m <= 255 && !stop; m++) begin
        int u, n, n2;
        u = r / m;
        if (u < 12) break;
        if (u > 38) continue;
        n = v2 * m / r;
        n2 = (v2 * m + r - 1) / r;
        if (n > 255) break;
        for (int k = n; k <= n2 && !stop; k++) begin
          int vco, lw, d;
          if (k < 8) continue;
          if (k > 255) break;
          vco = r * k / m;
          if (vco >= 1000 && vco <= vmx) begin
            lw = (vco + rt(p) / 2) / rt(p);
            d = (lw > tg) ? lw - tg : tg - lw;
            if (d < oe) begin
              oe = d; om = m; on = k; opl = p;
              if (d == 0) stop = 1;
            end
          end
        end
      end
    end
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    applied++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk);
      if (done_o) begin ok = 1; break; end
    end
  endtask

  task automatic launch(input int f, input int r);
    @(negedge clk);
    target_i = 10'(f); ref_i = 8'(r); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic check_result(input string req, input int f, input int r);
    int em, en, epl, ee;
    model(f, r, em, en, epl, ee);
    chk({req, " m"}, int'(m_o), em);
    chk({req, " n"}, int'(n_o), en);
    chk({req, " pl"}, int'(pl_o), epl);
    chk({req, " err"}, int'(err_o), ee);
    chk("R12 exact", int'(exact_o), int'(ee == 0));
  endtask

  task automatic run_one(input string req, input int f, input int r);
    bit ok;
    launch(f, r);
    chk("R2 busy after start", int'(busy_o), 1);
    wait_done(ok);
    chk("R3 done seen", int'(ok), 1);
    check_result(req, f, r);
    @(negedge clk);
    chk("R3 done one cycle", int'(done_o), 0);
    chk("R3 idle after done", int'(busy_o), 0);
  endtask

  task automatic t_reset;
    chk("R1 busy", int'(busy_o), 0);
    chk("R1 done", int'(done_o), 0);
    chk("R1 m", int'(m_o), 255);
    chk("R1 n", int'(n_o), 8);
    chk("R1 pl", int'(pl_o), 1);
    chk("R1 err", int'(err_o), 65535);
    chk("R1 exact", int'(exact_o), 0);
  endtask

  task automatic t_known_exact;
    run_one("R9 early exit", 72, 12);
    chk("R9 known m", int'(m_o), 1);
    chk("R9 known n", int'(n_o), 96);
    chk("R4 known pl", int'(pl_o), 6);
    chk("R8 known err", int'(err_o), 0);
  endtask

  task automatic t_no_match;
    run_one("R10 fallback", 300, 5);
    chk("R10 m", int'(m_o), 255);
    chk("R10 n", int'(n_o), 8);
    chk("R10 pl", int'(pl_o), 1);
    chk("R10 err", int'(err_o), 65535);
    chk("R10 exact", int'(exact_o), 0);
  endtask

  task automatic t_raised_ceiling;
    run_one("R5 raised ceiling", 1023, 38);
    run_one("R5 small target", 60, 27);
  endtask

  task automatic t_sweep;
    int tg[12] = '{60, 100, 150, 233, 300, 407, 500, 640, 777, 900, 1000, 1023};
    int rf[3] = '{12, 27, 38};
    foreach (tg[i]) foreach (rf[j]) run_one("R6 R7 R8 sweep", tg[i], rf[j]);
  endtask

  task automatic t_start_while_busy;
    bit ok;
    launch(150, 27);
    repeat (30) @(negedge clk);
    target_i = 10'd900; ref_i = 8'd12; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_done(ok);
    chk("R2 done after busy start", int'(ok), 1);
    check_result("R2 start ignored when busy", 150, 27);
    @(negedge clk);
  endtask

  task automatic t_start_in_done;
    bit ok;
    int sm, sn, sp, se;
    launch(407, 38);
    wait_done(ok);
    chk("R2 done", int'(ok), 1);
    sm = m_o; sn = n_o; sp = pl_o; se = err_o;
    target_i = 10'd100; ref_i = 8'd12; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R2 start in done cycle ignored busy", int'(busy_o), 0);
    repeat (3) @(negedge clk);
    chk("R2 no restart busy", int'(busy_o), 0);
    chk("R11 hold m", int'(m_o), sm);
    chk("R11 hold n", int'(n_o), sn);
    chk("R11 hold pl", int'(pl_o), sp);
    chk("R11 hold err", int'(err_o), se);
    run_one("R2 start accepted afterwards", 100, 12);
  endtask

  task automatic t_hold;
    int sm, sn, sp, se;
    sm = m_o; sn = n_o; sp = pl_o; se = err_o;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      target_i = 10'(i * 23); ref_i = 8'(i * 7);
    end
    chk("R11 idle m", int'(m_o), sm);
    chk("R11 idle n", int'(n_o), sn);
    chk("R11 idle pl", int'(pl_o), sp);
    chk("R11 idle err", int'(err_o), se);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000 && !finished) begin
        finished = 1;
        applied++; bad++;
        $display("FAIL watchdog all R actual=%0d expected=<190000", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_known_exact();
    t_no_match();
    t_raised_ceiling();
    t_start_while_busy();
    t_start_in_done();
    t_hold();
    t_sweep();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule